// File: doc/BRIEF.md
# Multi-Cycle Load/Store Integer Core

This block is a small non-pipelined 32-bit integer processor. Every instruction walks through up to five sequential steps: fetch, decode with register read, execute or address generation, memory access or branch completion, and register write-back. Only one instruction is in flight at any time. Intermediate results are held in step latches: the fetched word, the next sequential address, the two register operands, the extended immediate, the execute result, the branch condition and the loaded data word.

The core drives a word-wide instruction port and a data port. Both ports carry byte addresses and are read combinationally within the same cycle. The data port has a one-cycle read strobe and a one-cycle write strobe. The register file holds 32 words, and entry 0 is hard-wired to zero. A halt instruction stops the core. A debug read port lets a testbench inspect any register at any time.

Top module: `mc_risc_core`

## Requirements
- R1: While reset is active, imem_addr is 0, halted is 0, and dmem_rd and dmem_wr are both 0. After reset every register reads 0, and the first fetch is taken from address 0.
- R2: Register 0 always reads as zero. An instruction that names register 0 as its destination leaves it at zero.
- R3: Field positions, with bit 31 the most significant. opcode is [31:26] and rs1 is [25:21]. In I-type words the destination is [20:16] and the immediate is [15:0], sign-extended for every use. In R-type words rs2 is [20:16], the destination is [15:11], and the function code is the low 6 bits [5:0] of the 11-bit field [10:0]. In J-type words [25:0] is a signed byte offset.
- R4: R-type (opcode 0x00) functions: ADD 0x20, SUB 0x22, AND 0x24, OR 0x25, SLT 0x2A (1 if rs1 < rs2 as signed numbers, else 0), SLL 0x04 and SRL 0x06. The shift amount is rs2[4:0], and SRL fills with zeros.
- R5: Immediate operations write rs1 op sext(imm) to the I-type destination: ADDI 0x08, SUBI 0x0A, ANDI 0x0C, ORI 0x0D.
- R6: LW 0x23 reads the word at rs1 + sext(imm) into the I-type destination. SW 0x2B writes the register in [20:16] to rs1 + sext(imm). Each access asserts dmem_rd or dmem_wr for exactly one cycle, never both at once.
- R7: BEQZ 0x04 and BNEZ 0x05 test rs1 for zero or for non-zero. When taken, the next PC is (PC+4) + sext(imm). Otherwise it is PC+4.
- R8: J 0x02 and JAL 0x03 set the next PC to (PC+4) + sext(offset26). JAL also writes PC+4 into register 31.
- R9: Each instruction takes a fixed number of cycles. Register-writing instructions (R-type, immediate, LW, JAL) take 5 cycles. SW, branches, J and unknown opcodes take 4 cycles and skip write-back.
- R10: HALT 0x3F raises halted two cycles after its fetch. halted then stays high, imem_addr stays at the address of the HALT word, and no further data access occurs.
- R11: dbg_data combinationally shows the register selected by dbg_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Byte address of the instruction being fetched (the PC) |
| imem_rdata | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 32 | Byte address of the data access |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data at dmem_addr, same cycle |
| dmem_rd | output | 1 | Load strobe, one cycle |
| dmem_wr | output | 1 | Store strobe, one cycle |
| halted | output | 1 | High once a HALT instruction has been decoded |
| dbg_sel | input | 5 | Debug register index |
| dbg_data | output | 32 | Contents of the register at dbg_sel |

## Verification
The test program combines a positive and a negative register operand through every ALU function. Mixed signs separate signed from unsigned SLT, sign-extended from zero-extended immediates, and logical from arithmetic right shift. A write to register 0 shows whether the zero register can be overwritten. Branches are run both taken and not taken on zero and non-zero operands, and jumps use forward and backward offsets, so offset sign handling and the condition polarity are both exposed. The program also contains skipped instructions, a store that is read back, and an exact cycle count to halt. Together these catch wrong targets, wrongly executed instructions, misplaced destination fields and wrong step counts.

// File: rtl/risc_pkg.sv
package risc_pkg;

   typedef enum logic [2:0] {
      ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB, ST_HALT
   } step_e;

   typedef enum logic [2:0] {
      ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT, ALU_SLL, ALU_SRL
   } alu_op_e;

   typedef enum logic [2:0] {
      CL_ALU_R, CL_ALU_I, CL_LOAD, CL_STORE, CL_BRANCH, CL_JUMP, CL_HALT, CL_NOP
   } iclass_e;

   localparam logic [5:0] OP_RTYPE = 6'h00;
   localparam logic [5:0] OP_J     = 6'h02;
   localparam logic [5:0] OP_JAL   = 6'h03;
   localparam logic [5:0] OP_BEQZ  = 6'h04;
   localparam logic [5:0] OP_BNEZ  = 6'h05;
   localparam logic [5:0] OP_ADDI  = 6'h08;
   localparam logic [5:0] OP_SUBI  = 6'h0A;
   localparam logic [5:0] OP_ANDI  = 6'h0C;
   localparam logic [5:0] OP_ORI   = 6'h0D;
   localparam logic [5:0] OP_LW    = 6'h23;
   localparam logic [5:0] OP_SW    = 6'h2B;
   localparam logic [5:0] OP_HALT  = 6'h3F;

   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_SLT = 6'h2A;
   localparam logic [5:0] FN_SLL = 6'h04;
   localparam logic [5:0] FN_SRL = 6'h06;

endpackage

// File: rtl/risc_decode.sv
module risc_decode
   import risc_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int RA_W     = 5,
   parameter int LINK_REG = 31
) (
   input  logic [XLEN-1:0] ir,
   output iclass_e         cls,
   output alu_op_e         alu_op,
   output logic            link,
   output logic            br_zero,
   output logic [RA_W-1:0] dest
);
   logic [5:0] opc;
   logic [5:0] fn;
   logic       unused_bits;

   assign opc = ir[31:26];
   assign fn  = ir[5:0];
   assign unused_bits = ^ir[10:6];

   always_comb begin
      cls     = CL_NOP;
      alu_op  = ALU_ADD;
      link    = 1'b0;
      br_zero = 1'b0;
      unique case (opc)
         OP_RTYPE: begin
            cls = CL_ALU_R;
            unique case (fn)
               FN_ADD:  alu_op = ALU_ADD;
               FN_SUB:  alu_op = ALU_SUB;
               FN_AND:  alu_op = ALU_AND;
               FN_OR:   alu_op = ALU_OR;
               FN_SLT:  alu_op = ALU_SLT;
               FN_SLL:  alu_op = ALU_SLL;
               FN_SRL:  alu_op = ALU_SRL;
               default: cls = CL_NOP;
            endcase
         end
         OP_J:    cls = CL_JUMP;
         OP_JAL:  begin cls = CL_JUMP; link = 1'b1; end
         OP_BEQZ: begin cls = CL_BRANCH; br_zero = 1'b1; end
         OP_BNEZ: cls = CL_BRANCH;
         OP_ADDI: cls = CL_ALU_I;
         OP_SUBI: begin cls = CL_ALU_I; alu_op = ALU_SUB; end
         OP_ANDI: begin cls = CL_ALU_I; alu_op = ALU_AND; end
         OP_ORI:  begin cls = CL_ALU_I; alu_op = ALU_OR; end
         OP_LW:   cls = CL_LOAD;
         OP_SW:   cls = CL_STORE;
         OP_HALT: cls = CL_HALT;
         default: cls = CL_NOP;
      endcase
   end

   // destination field moves with the format
   always_comb begin
      if (link)
         dest = RA_W'(LINK_REG);
      else if (cls == CL_ALU_R)
         dest = ir[15:11];
      else
         dest = ir[20:16];
   end
endmodule

// File: rtl/risc_alu.sv
module risc_alu
   import risc_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] opa,
   input  logic [XLEN-1:0] opb,
   input  alu_op_e         op,
   output logic [XLEN-1:0] res
);
   localparam int SH_W = $clog2(XLEN);

   logic [SH_W-1:0] shamt;
   assign shamt = opb[SH_W-1:0];

   always_comb begin
      unique case (op)
         ALU_ADD: res = opa + opb;
         ALU_SUB: res = opa - opb;
         ALU_AND: res = opa & opb;
         ALU_OR:  res = opa | opb;
         ALU_SLT: res = {{(XLEN-1){1'b0}}, ($signed(opa) < $signed(opb))};
         ALU_SLL: res = opa << shamt;
         ALU_SRL: res = opa >> shamt;
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/risc_regfile.sv
module risc_regfile #(
   parameter int XLEN     = 32,
   parameter int REG_CNT  = 32,
   parameter bit RF_CLEAR = 1'b1,
   localparam int RA_W    = $clog2(REG_CNT)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [RA_W-1:0] ra1,
   input  logic [RA_W-1:0] ra2,
   input  logic [RA_W-1:0] ra3,
   input  logic            we,
   input  logic [RA_W-1:0] wa,
   input  logic [XLEN-1:0] wd,
   output logic [XLEN-1:0] rd1,
   output logic [XLEN-1:0] rd2,
   output logic [XLEN-1:0] rd3
);
   logic [XLEN-1:0] regs [REG_CNT];

   assign regs[0] = '0;

   for (genvar i = 1; i < REG_CNT; i++) begin : g_reg
      if (RF_CLEAR) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               regs[i] <= '0;
            else if (we && wa == RA_W'(i))
               regs[i] <= wd;
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (we && wa == RA_W'(i))
               regs[i] <= wd;
         end
      end
   end

   assign rd1 = regs[ra1];
   assign rd2 = regs[ra2];
   assign rd3 = regs[ra3];
endmodule

// File: rtl/risc_seq.sv
module risc_seq
   import risc_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  iclass_e cls,
   input  logic    link,
   output step_e   step
);
   step_e nxt;

   always_comb begin
      nxt = step;
      unique case (step)
         ST_FETCH:  nxt = ST_DECODE;
         ST_DECODE: nxt = (cls == CL_HALT) ? ST_HALT : ST_EXEC;
         ST_EXEC:   nxt = ST_MEM;
         ST_MEM: begin
            if (cls == CL_ALU_R || cls == CL_ALU_I || cls == CL_LOAD ||
                (cls == CL_JUMP && link))
               nxt = ST_WB;
            else
               nxt = ST_FETCH;
         end
         ST_WB:     nxt = ST_FETCH;
         ST_HALT:   nxt = ST_HALT;
         default:   nxt = ST_FETCH;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) step <= ST_FETCH;
      else        step <= nxt;
   end
endmodule

// File: rtl/mc_risc_core.sv
module mc_risc_core
   import risc_pkg::*;
#(
   parameter int          XLEN     = 32,
   parameter int          REG_CNT  = 32,
   parameter int          LINK_REG = 31,
   parameter logic [31:0] RESET_PC = 32'h0,
   parameter bit          RF_CLEAR = 1'b1,
   localparam int         RA_W     = $clog2(REG_CNT),
   localparam int         IMM_W    = 16,
   localparam int         JOFF_W   = 26
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [XLEN-1:0] imem_addr,
   input  logic [XLEN-1:0] imem_rdata,
   output logic [XLEN-1:0] dmem_addr,
   output logic [XLEN-1:0] dmem_wdata,
   input  logic [XLEN-1:0] dmem_rdata,
   output logic            dmem_rd,
   output logic            dmem_wr,
   output logic            halted,
   input  logic [RA_W-1:0] dbg_sel,
   output logic [XLEN-1:0] dbg_data
);
   if (XLEN != 32) begin : g_bad_xlen
      $error("mc_risc_core: instruction fields require XLEN of 32");
   end
   if (REG_CNT != 32) begin : g_bad_regs
      $error("mc_risc_core: 5-bit register fields require REG_CNT of 32");
   end
   if (LINK_REG <= 0 || LINK_REG >= REG_CNT) begin : g_bad_link
      $error("mc_risc_core: LINK_REG out of range");
   end

   step_e           step;
   iclass_e         cls;
   alu_op_e         alu_op;
   logic            link, br_zero;
   logic [RA_W-1:0] dest;

   logic [XLEN-1:0] pc, ir, npc, a_q, b_q, imm_q, alu_q, lmd_q;
   logic            cond_q;
   logic [XLEN-1:0] rf_a, rf_b, joff, opa, opb, alu_y, wb_data;
   logic            rf_we;

   risc_seq u_seq (
      .clk(clk), .rst_n(rst_n), .cls(cls), .link(link), .step(step)
   );

   risc_decode #(.XLEN(XLEN), .RA_W(RA_W), .LINK_REG(LINK_REG)) u_dec (
      .ir(ir), .cls(cls), .alu_op(alu_op), .link(link),
      .br_zero(br_zero), .dest(dest)
   );

   risc_regfile #(.XLEN(XLEN), .REG_CNT(REG_CNT), .RF_CLEAR(RF_CLEAR)) u_rf (
      .clk(clk), .rst_n(rst_n),
      .ra1(ir[25:21]), .ra2(ir[20:16]), .ra3(dbg_sel),
      .we(rf_we), .wa(dest), .wd(wb_data),
      .rd1(rf_a), .rd2(rf_b), .rd3(dbg_data)
   );

   assign joff = {{(XLEN-JOFF_W){ir[JOFF_W-1]}}, ir[JOFF_W-1:0]};

   // one adder serves ALU ops, addresses and control-flow targets
   assign opa = (cls == CL_BRANCH || cls == CL_JUMP) ? npc : a_q;
   assign opb = (cls == CL_ALU_R) ? b_q : (cls == CL_JUMP) ? joff : imm_q;

   risc_alu #(.XLEN(XLEN)) u_alu (
      .opa(opa), .opb(opb), .op(alu_op), .res(alu_y)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc     <= RESET_PC;
         ir     <= '0;
         npc    <= '0;
         a_q    <= '0;
         b_q    <= '0;
         imm_q  <= '0;
         alu_q  <= '0;
         lmd_q  <= '0;
         cond_q <= 1'b0;
      end else begin
         unique case (step)
            ST_FETCH: begin
               ir  <= imem_rdata;
               npc <= pc + XLEN'(4);
            end
            ST_DECODE: begin
               a_q   <= rf_a;
               b_q   <= rf_b;
               imm_q <= {{(XLEN-IMM_W){ir[IMM_W-1]}}, ir[IMM_W-1:0]};
            end
            ST_EXEC: begin
               alu_q <= alu_y;
               if (cls == CL_BRANCH)
                  cond_q <= br_zero ? (a_q == '0) : (a_q != '0);
               else
                  cond_q <= (cls == CL_JUMP);
            end
            ST_MEM: begin
               if (cls == CL_LOAD) lmd_q <= dmem_rdata;
               pc <= cond_q ? alu_q : npc;
            end
            default: ;
         endcase
      end
   end

   assign wb_data = (cls == CL_LOAD) ? lmd_q : link ? npc : alu_q;
   assign rf_we   = (step == ST_WB);

   assign imem_addr  = pc;
   assign dmem_addr  = alu_q;
   assign dmem_wdata = b_q;
   assign dmem_rd    = (step == ST_MEM) && (cls == CL_LOAD);
   assign dmem_wr    = (step == ST_MEM) && (cls == CL_STORE);
   assign halted     = (step == ST_HALT);
endmodule

// File: rtl/mc_risc_core_chk.sv
module mc_risc_core_chk #(
   parameter int XLEN = 32,
   parameter int RA_W = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic [XLEN-1:0] imem_addr,
   input logic            dmem_rd,
   input logic            dmem_wr,
   input logic            halted,
   input logic [RA_W-1:0] dbg_sel,
   input logic [XLEN-1:0] dbg_data
);
   // R6
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(dmem_rd && dmem_wr));

   // R6
   wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dmem_wr |=> !dmem_wr);

   // R6
   rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dmem_rd |=> !dmem_rd);

   // R10
   halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   // R10
   halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> (!dmem_rd && !dmem_wr));

   // R10
   halt_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> $stable(imem_addr));

   // R2
   zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_sel == '0) |-> (dbg_data == '0));

   // R9
   fetch_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      imem_addr[1:0] == 2'b00);
endmodule

bind mc_risc_core mc_risc_core_chk #(.XLEN(XLEN), .RA_W(RA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .dmem_rd(dmem_rd),
   .dmem_wr(dmem_wr), .halted(halted), .dbg_sel(dbg_sel), .dbg_data(dbg_data)
);

// File: tb/tb_mc_risc_core.sv
`timescale 1ns/1ps
module tb_mc_risc_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata, dbg_data;
   logic        dmem_rd, dmem_wr, halted;
   logic [4:0]  dbg_sel = 5'd0;

   always #5 clk = ~clk;

   mc_risc_core dut (
      .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
      .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
      .dmem_rd(dmem_rd), .dmem_wr(dmem_wr), .halted(halted),
      .dbg_sel(dbg_sel), .dbg_data(dbg_data)
   );

   logic [31:0] imem [64];
   logic [31:0] dmem [16];
   assign imem_rdata = imem[imem_addr[7:2]];
   assign dmem_rdata = dmem[dmem_addr[5:2]];
   always @(posedge clk) if (dmem_wr) dmem[dmem_addr[5:2]] <= dmem_wdata;

   int n_chk = 0;
   int n_fail = 0;

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // scoreboard of data-port accesses
   typedef struct { bit wr; logic [31:0] addr; logic [31:0] data; } acc_t;
   acc_t exp_q[$];

   task automatic push_acc(bit wr, logic [31:0] addr, logic [31:0] data);
      acc_t a;
      a.wr = wr; a.addr = addr; a.data = data;
      exp_q.push_back(a);
   endtask

   always @(negedge clk) begin
      if (rst_n && (dmem_rd || dmem_wr)) begin
         if (exp_q.size() == 0) begin
            check("R6", "unexpected data access", {31'd0, dmem_wr}, 32'hx);
         end else begin
            acc_t e;
            e = exp_q.pop_front();
            check("R6", "access kind (1=write)", {31'd0, dmem_wr}, {31'd0, e.wr});
            check("R6", "access address", dmem_addr, e.addr);
            if (e.wr) check("R6", "store data", dmem_wdata, e.data);
         end
      end
   end

   function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rd, logic [15:0] imm);
      return {op, rs, rd, imm};
   endfunction
   function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
      return {6'h00, rs, rt, rd, 5'd0, fn};
   endfunction
   function automatic logic [31:0] enc_j(logic [5:0] op, logic [25:0] off);
      return {op, off};
   endfunction

   logic [31:0] exp_rf [32];
   string       rf_tag [32];

   initial begin
      int ncyc;
      for (int i = 0; i < 64; i++) imem[i] = 32'hFC00_0000;   // HALT filler
      for (int i = 0; i < 16; i++) dmem[i] = 32'h0;
      dmem[5] = 32'h1234_5678;

      imem[0]  = enc_i(6'h08, 5'd0, 5'd1, 16'd5);        // ADDI r1 = 5
      imem[1]  = enc_i(6'h08, 5'd0, 5'd2, 16'hFFFD);     // ADDI r2 = -3
      imem[2]  = enc_r(5'd1, 5'd2, 5'd3, 6'h20);         // ADD
      imem[3]  = enc_r(5'd1, 5'd2, 5'd4, 6'h22);         // SUB
      imem[4]  = enc_r(5'd1, 5'd2, 5'd5, 6'h24);         // AND
      imem[5]  = enc_r(5'd1, 5'd2, 5'd6, 6'h25);         // OR
      imem[6]  = enc_r(5'd2, 5'd1, 5'd7, 6'h2A);         // SLT -3<5
      imem[7]  = enc_r(5'd1, 5'd2, 5'd8, 6'h2A);         // SLT 5<-3
      imem[8]  = enc_r(5'd1, 5'd3, 5'd9, 6'h04);         // SLL 5<<2
      imem[9]  = enc_r(5'd2, 5'd4, 5'd10, 6'h06);        // SRL >>8
      imem[10] = enc_i(6'h0C, 5'd2, 5'd11, 16'h00F0);    // ANDI
      imem[11] = enc_i(6'h0D, 5'd0, 5'd12, 16'h8001);    // ORI sext
      imem[12] = enc_i(6'h0A, 5'd1, 5'd13, 16'd7);       // SUBI
      imem[13] = enc_i(6'h08, 5'd1, 5'd0, 16'd9);        // ADDI r0 (ignored)
      imem[14] = enc_i(6'h2B, 5'd4, 5'd1, 16'd4);        // SW r1 -> 12
      imem[15] = enc_i(6'h2B, 5'd4, 5'd6, 16'hFFFC);     // SW r6 -> 4
      imem[16] = enc_i(6'h23, 5'd4, 5'd14, 16'd4);       // LW r14 <- 12
      imem[17] = enc_i(6'h23, 5'd0, 5'd15, 16'd20);      // LW r15 <- 20
      imem[18] = enc_i(6'h04, 5'd8, 5'd0, 16'd4);        // BEQZ r8 taken
      imem[19] = enc_i(6'h08, 5'd0, 5'd16, 16'd1);       // skipped
      imem[20] = enc_i(6'h05, 5'd8, 5'd0, 16'd4);        // BNEZ r8 not taken
      imem[21] = enc_i(6'h05, 5'd7, 5'd0, 16'd4);        // BNEZ r7 taken
      imem[22] = enc_i(6'h08, 5'd0, 5'd17, 16'd1);       // skipped
      imem[23] = enc_j(6'h03, 26'd4);                    // JAL -> 100
      imem[24] = enc_i(6'h08, 5'd0, 5'd18, 16'd1);       // skipped
      imem[25] = enc_i(6'h04, 5'd7, 5'd0, 16'd4);        // BEQZ r7 not taken
      imem[26] = enc_j(6'h02, 26'd8);                    // J -> 116
      imem[27] = enc_i(6'h2B, 5'd0, 5'd31, 16'd0);       // SW r31 -> 0
      imem[28] = 32'hFC00_0000;                          // HALT
      imem[29] = enc_j(6'h02, 26'h3FF_FFF4);             // J back -> 108

      for (int i = 0; i < 32; i++) begin exp_rf[i] = 32'h0; rf_tag[i] = "R2"; end
      exp_rf[1]  = 32'd5;        rf_tag[1]  = "R5";
      exp_rf[2]  = 32'hFFFF_FFFD; rf_tag[2] = "R5";
      exp_rf[3]  = 32'd2;        rf_tag[3]  = "R4";
      exp_rf[4]  = 32'd8;        rf_tag[4]  = "R4";
      exp_rf[5]  = 32'd5;        rf_tag[5]  = "R4";
      exp_rf[6]  = 32'hFFFF_FFFD; rf_tag[6] = "R4";
      exp_rf[7]  = 32'd1;        rf_tag[7]  = "R4";
      exp_rf[8]  = 32'd0;        rf_tag[8]  = "R4";
      exp_rf[9]  = 32'd20;       rf_tag[9]  = "R4";
      exp_rf[10] = 32'h00FF_FFFF; rf_tag[10] = "R4";
      exp_rf[11] = 32'h0000_00F0; rf_tag[11] = "R5";
      exp_rf[12] = 32'hFFFF_8001; rf_tag[12] = "R3";
      exp_rf[13] = 32'hFFFF_FFFE; rf_tag[13] = "R5";
      exp_rf[14] = 32'd5;        rf_tag[14] = "R6";
      exp_rf[15] = 32'h1234_5678; rf_tag[15] = "R6";
      rf_tag[16] = "R7"; rf_tag[17] = "R7"; rf_tag[18] = "R8";
      exp_rf[31] = 32'd96;       rf_tag[31] = "R8";

      push_acc(1'b1, 32'd12, 32'd5);
      push_acc(1'b1, 32'd4,  32'hFFFF_FFFD);
      push_acc(1'b0, 32'd12, 32'h0);
      push_acc(1'b0, 32'd20, 32'h0);
      push_acc(1'b1, 32'd0,  32'd96);

      // R1 reset state
      repeat (3) @(posedge clk);
      dbg_sel = 5'd5;
      #1;
      check("R1", "imem_addr in reset", imem_addr, 32'h0);
      check("R1", "halted in reset", {31'd0, halted}, 32'h0);
      check("R1", "dmem_rd in reset", {31'd0, dmem_rd}, 32'h0);
      check("R1", "dmem_wr in reset", {31'd0, dmem_wr}, 32'h0);
      check("R11", "debug read after reset", dbg_data, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R9 exact cycle count to halt, with watchdog
      ncyc = 0;
      while (1) begin
         @(posedge clk);
         ncyc++;
         #1;
         if (halted || ncyc > 2000) break;
      end
      if (ncyc > 2000)
         check("R9", "watchdog expired before halt", 32'd0, 32'd1);
      check("R9", "cycles to halted", ncyc, 32'd123);
      check("R10", "imem_addr at halt", imem_addr, 32'd112);
      repeat (10) @(posedge clk);
      #1;
      check("R10", "halted held", {31'd0, halted}, 32'd1);
      check("R10", "imem_addr held", imem_addr, 32'd112);
      check("R6", "all expected accesses seen", exp_q.size(), 32'd0);
      check("R6", "store-then-load word in memory", dmem[3], 32'd5);

      // R11 debug port readback of every register
      for (int i = 0; i < 32; i++) begin
         dbg_sel = 5'(i);
         #1;
         check(rf_tag[i], $sformatf("r%0d value", i), dbg_data, exp_rf[i]);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule